// File: doc/BRIEF.md
# Sub-Word Accessible Register File

This block holds sixteen 64-bit integer registers with two read ports and one write port. Each port names a register and a view of it. The view can be the whole register, or one of the three low-order slices: 32, 16 or 8 bits. A fifth view reaches the second byte (bits 15:8), and only on the four lowest-numbered registers. Reads return the chosen view zero-extended to the full width. Writes change only the chosen slice. The exception is the 32-bit view, which also clears the upper half of the register. An execution datapath uses the block to carry out narrow-operand moves and arithmetic. All decoding of instructions is done elsewhere.

Reads are combinational from the stored state. A write lands on the rising clock edge. A read of the entry being written in that same cycle therefore sees the old contents. Entry 4 is an ordinary storage location here, even though other blocks reserve it for stack use. An access whose view is not allowed for its register raises an error flag on its port. A flagged write changes nothing, and a flagged read returns zero.

Top module: `regv_file`

## Requirements
- R1: After reset is asserted (rst_n low), every one of the 16 entries reads as zero through the full view.
- R2: A write with view code 0 (full) replaces all 64 bits with wr_data, and a read with view code 0 returns all 64 bits.
- R3: A read with view code 1, 2 or 3 returns bits 31:0, 15:0 or 7:0 of the entry in the same result positions, with every higher result bit zero.
- R4: A read with view code 4 on entries 0 to 3 returns entry bits 15:8 in result bits 7:0, with every other result bit zero.
- R5: A write with view code 1 stores wr_data[31:0] into bits 31:0 and clears bits 63:32.
- R6: A write with view code 2 stores wr_data[15:0] into bits 15:0 and leaves bits 63:16 unchanged.
- R7: A write with view code 3 stores wr_data[7:0] into bits 7:0 and leaves bits 63:8 unchanged.
- R8: A write with view code 4 on entries 0 to 3 stores wr_data[7:0] into bits 15:8 and leaves the other bits unchanged.
- R9: A write with a view code of 5 to 7, or with view code 4 on an entry above 3, drives wr_err high in that cycle, and no entry changes.
- R10: A read with a view code of 5 to 7, or with view code 4 on an entry above 3, drives that port's error flag high and returns zero.
- R11: A read of the entry being written in the same cycle returns the old contents, and the new contents are visible from the cycle after the write edge.
- R12: The two read ports select entries and views independently of each other, and entry 4 stores and returns data like any other entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd0_idx | input | 4 | Read port 0 entry select |
| rd0_view | input | 3 | Read port 0 view code |
| rd0_data | output | 64 | Read port 0 zero-extended result |
| rd0_err | output | 1 | Read port 0 illegal-access flag |
| rd1_idx | input | 4 | Read port 1 entry select |
| rd1_view | input | 3 | Read port 1 view code |
| rd1_data | output | 64 | Read port 1 zero-extended result |
| rd1_err | output | 1 | Read port 1 illegal-access flag |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Write entry select |
| wr_view | input | 3 | Write view code |
| wr_data | input | 64 | Write source; the slice is taken from its low bits |
| wr_err | output | 1 | Illegal write flag, combinational |

## Verification
Read results and both error flags are combinational. The bench therefore samples them one time unit after it drives the select inputs, in the same cycle. A write only becomes visible after the next rising edge. For that reason the bench drives each write on a falling edge, lets one rising edge pass, and reads the entry back on the following falling edge. For the same-cycle case, the bench samples once before the write edge and expects the old value. It samples again after the edge and expects the merged value.

// File: rtl/regv_pkg.sv
package regv_pkg;
    typedef enum logic [2:0] {
        VW_W64 = 3'd0,
        VW_W32 = 3'd1,
        VW_W16 = 3'd2,
        VW_LO8 = 3'd3,
        VW_HI8 = 3'd4
    } view_e;
endpackage

// File: rtl/regv_access_check.sv
module regv_access_check #(
    parameter int NREGS   = 16,
    parameter int HB_REGS = 4,
    localparam int IDX_W  = $clog2(NREGS)
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [2:0]       view,
    output logic             legal
);
    import regv_pkg::*;

    always_comb begin
        case (view_e'(view))
            VW_W64, VW_W32, VW_W16, VW_LO8: legal = 1'b1;
            VW_HI8:                         legal = (32'(idx) < HB_REGS);
            default:                        legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/regv_read_view.sv
module regv_read_view #(
    parameter int XLEN  = 64,
    localparam int HALF = XLEN / 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] word,
    input  logic [2:0]      view,
    input  logic            legal,
    output logic [XLEN-1:0] data,
    output logic            err
);
    import regv_pkg::*;

    assign err = !legal;

    always_comb begin
        data = '0;
        if (legal) begin
            case (view_e'(view))
                VW_W64: data = word;
                VW_W32: data[HALF-1:0] = word[HALF-1:0];
                VW_W16: data[15:0] = word[15:0];
                VW_LO8: data[7:0] = word[7:0];
                VW_HI8: data[7:0] = word[15:8];
                default: data = '0;
            endcase
        end
    end

    // R10
    rd_err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (data == '0));

    // R3
    rd_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!err && view == 3'd1) |-> (data[XLEN-1:HALF] == '0));

    // R4
    rd_hibyte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!err && view == 3'd4) |-> (data[XLEN-1:8] == '0 && data[7:0] == word[15:8]));
endmodule

// File: rtl/regv_write_merge.sv
module regv_write_merge #(
    parameter int XLEN  = 64,
    localparam int HALF = XLEN / 2
) (
    input  logic [XLEN-1:0] old_word,
    input  logic [XLEN-1:0] wdata,
    input  logic [2:0]      view,
    output logic [XLEN-1:0] new_word
);
    import regv_pkg::*;

    always_comb begin
        new_word = old_word;
        case (view_e'(view))
            VW_W64: new_word = wdata;
            VW_W32: new_word = {{HALF{1'b0}}, wdata[HALF-1:0]};
            VW_W16: new_word[15:0] = wdata[15:0];
            VW_LO8: new_word[7:0] = wdata[7:0];
            VW_HI8: new_word[15:8] = wdata[7:0];
            default: new_word = old_word;
        endcase
    end
endmodule

// File: rtl/regv_file.sv
module regv_file #(
    parameter int NREGS   = 16,
    parameter int XLEN    = 64,
    parameter int HB_REGS = 4,
    localparam int IDX_W  = $clog2(NREGS),
    localparam int HALF   = XLEN / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd0_idx,
    input  logic [2:0]       rd0_view,
    output logic [XLEN-1:0]  rd0_data,
    output logic             rd0_err,
    input  logic [IDX_W-1:0] rd1_idx,
    input  logic [2:0]       rd1_view,
    output logic [XLEN-1:0]  rd1_data,
    output logic             rd1_err,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [2:0]       wr_view,
    input  logic [XLEN-1:0]  wr_data,
    output logic             wr_err
);
    logic [XLEN-1:0] regs [NREGS];
    logic            wr_legal;
    logic            rd0_legal;
    logic            rd1_legal;
    logic [XLEN-1:0] merged;

    regv_access_check #(.NREGS(NREGS), .HB_REGS(HB_REGS)) u_wchk (
        .idx(wr_idx), .view(wr_view), .legal(wr_legal));
    regv_access_check #(.NREGS(NREGS), .HB_REGS(HB_REGS)) u_r0chk (
        .idx(rd0_idx), .view(rd0_view), .legal(rd0_legal));
    regv_access_check #(.NREGS(NREGS), .HB_REGS(HB_REGS)) u_r1chk (
        .idx(rd1_idx), .view(rd1_view), .legal(rd1_legal));

    assign wr_err = wr_en && !wr_legal;

    regv_write_merge #(.XLEN(XLEN)) u_merge (
        .old_word(regs[wr_idx]), .wdata(wr_data), .view(wr_view), .new_word(merged));

    for (genvar g = 0; g < NREGS; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_en && wr_legal && (32'(wr_idx) == g))
                regs[g] <= merged;
        end
    end

    regv_read_view #(.XLEN(XLEN)) u_rd0 (
        .clk(clk), .rst_n(rst_n), .word(regs[rd0_idx]), .view(rd0_view),
        .legal(rd0_legal), .data(rd0_data), .err(rd0_err));
    regv_read_view #(.XLEN(XLEN)) u_rd1 (
        .clk(clk), .rst_n(rst_n), .word(regs[rd1_idx]), .view(rd1_view),
        .legal(rd1_legal), .data(rd1_data), .err(rd1_err));

    // R9
    wr_illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> (regs[$past(wr_idx)] == $past(regs[wr_idx])));

    // R5
    wr_w32_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_err && wr_view == 3'd1) |=> (regs[$past(wr_idx)][XLEN-1:HALF] == '0));

    // R6
    wr_w16_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_err && wr_view == 3'd2)
        |=> (regs[$past(wr_idx)][XLEN-1:16] == $past(regs[wr_idx][XLEN-1:16])));

    // R8
    wr_hi8_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_err && wr_view == 3'd4)
        |=> (regs[$past(wr_idx)][7:0] == $past(regs[wr_idx][7:0])));
endmodule

// File: tb/regv_file_tb.sv
module regv_file_tb;
    typedef struct packed {
        logic [3:0]  idx;
        logic [2:0]  view;
        logic [63:0] data;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  3'd0, 64'hDEAD_BEEF_0123_4567},
        '{4'd0,  3'd1, 64'hFFFF_FFFF_89AB_CDEF},
        '{4'd1,  3'd0, 64'h1111_2222_3333_4444},
        '{4'd1,  3'd2, 64'hAAAA_BBBB_CCCC_5A5A},
        '{4'd2,  3'd0, 64'h0F0F_0F0F_0F0F_0F0F},
        '{4'd2,  3'd3, 64'h0000_0000_0000_00C3},
        '{4'd3,  3'd0, 64'h8765_4321_FEDC_BA98},
        '{4'd3,  3'd4, 64'hFFFF_FFFF_FFFF_FF7E},
        '{4'd4,  3'd0, 64'h0123_4567_89AB_CDEF},
        '{4'd4,  3'd2, 64'h0000_0000_0000_BEEF},
        '{4'd15, 3'd0, 64'hCAFE_F00D_1234_5678},
        '{4'd15, 3'd1, 64'h0000_0000_7654_3210}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd0_idx = '0, rd1_idx = '0, wr_idx = '0;
    logic [2:0]  rd0_view = '0, rd1_view = '0, wr_view = '0;
    logic [63:0] rd0_data, rd1_data, wr_data = '0;
    logic        rd0_err, rd1_err, wr_err;
    logic        wr_en = 1'b0;

    logic [63:0] model [16];
    int total = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    regv_file u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd0_idx(rd0_idx), .rd0_view(rd0_view), .rd0_data(rd0_data), .rd0_err(rd0_err),
        .rd1_idx(rd1_idx), .rd1_view(rd1_view), .rd1_data(rd1_data), .rd1_err(rd1_err),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_view(wr_view), .wr_data(wr_data), .wr_err(wr_err));

    function automatic logic [63:0] ref_merge(logic [63:0] o, logic [63:0] d, logic [2:0] v);
        case (v)
            3'd0: return d;
            3'd1: return {32'h0, d[31:0]};
            3'd2: return {o[63:16], d[15:0]};
            3'd3: return {o[63:8], d[7:0]};
            3'd4: return {o[63:16], d[7:0], o[7:0]};
            default: return o;
        endcase
    endfunction

    function automatic logic [63:0] ref_read(logic [63:0] w, logic [2:0] v);
        case (v)
            3'd0: return w;
            3'd1: return {32'h0, w[31:0]};
            3'd2: return {48'h0, w[15:0]};
            3'd3: return {56'h0, w[7:0]};
            3'd4: return {56'h0, w[15:8]};
            default: return 64'h0;
        endcase
    endfunction

    function automatic string wtag(logic [2:0] v);
        case (v)
            3'd0: return "R2";
            3'd1: return "R5";
            3'd2: return "R6";
            3'd3: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    task automatic do_write(logic [3:0] i, logic [2:0] v, logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = i; wr_view = v; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        total++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: all entries zero after reset
        for (int i = 0; i < 16; i++) begin
            rd0_idx = 4'(i); rd0_view = 3'd0;
            #1 chk("R1", rd0_data, 64'h0);
        end

        // Table walk: write, then read back in full and in the written view
        for (int k = 0; k < NV; k++) begin
            do_write(VECS[k].idx, VECS[k].view, VECS[k].data);
            model[VECS[k].idx] = ref_merge(model[VECS[k].idx], VECS[k].data, VECS[k].view);
            rd0_idx = VECS[k].idx; rd0_view = 3'd0;
            rd1_idx = VECS[k].idx; rd1_view = VECS[k].view;
            #1;
            chk(wtag(VECS[k].view), rd0_data, model[VECS[k].idx]);
            chk((VECS[k].view == 3'd4) ? "R4" : "R3", rd1_data,
                ref_read(model[VECS[k].idx], VECS[k].view));
        end

        // R3: narrow views of entry 0 on port 1
        rd1_idx = 4'd0;
        for (int v = 1; v < 4; v++) begin
            rd1_view = 3'(v);
            #1 chk("R3", rd1_data, ref_read(model[0], 3'(v)));
        end

        // R4: high byte of entry 1
        rd1_idx = 4'd1; rd1_view = 3'd4;
        #1 chk("R4", rd1_data, {56'h0, model[1][15:8]});

        // R12: ports independent, entry 4 ordinary storage
        rd0_idx = 4'd4; rd0_view = 3'd0; rd1_idx = 4'd3; rd1_view = 3'd3;
        #1;
        chk("R12", rd0_data, model[4]);
        chk("R12", rd1_data, {56'h0, model[3][7:0]});

        // R9: illegal writes flag and change nothing
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd6; wr_view = 3'd4; wr_data = 64'hFFFF_FFFF_FFFF_FFFF;
        #1 chk("R9", {63'h0, wr_err}, 64'h1);
        @(posedge clk); @(negedge clk);
        wr_idx = 4'd0; wr_view = 3'd5;
        #1 chk("R9", {63'h0, wr_err}, 64'h1);
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        rd0_idx = 4'd6; rd0_view = 3'd0; rd1_idx = 4'd0; rd1_view = 3'd0;
        #1;
        chk("R9", rd0_data, model[6]);
        chk("R9", rd1_data, model[0]);

        // R10: illegal reads flag and return zero
        rd0_idx = 4'd4; rd0_view = 3'd4; rd1_idx = 4'd0; rd1_view = 3'd7;
        #1;
        chk("R10", {63'h0, rd0_err}, 64'h1);
        chk("R10", rd0_data, 64'h0);
        chk("R10", {63'h0, rd1_err}, 64'h1);
        chk("R10", rd1_data, 64'h0);

        // R11: same-cycle read sees old value, new one after the edge
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd2; wr_view = 3'd0; wr_data = 64'h5555_6666_7777_8888;
        rd0_idx = 4'd2; rd0_view = 3'd0;
        #1 chk("R11", rd0_data, model[2]);
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        model[2] = 64'h5555_6666_7777_8888;
        #1 chk("R11", rd0_data, model[2]);

        // Final sweep of all entries on both ports
        for (int i = 0; i < 16; i++) begin
            rd0_idx = 4'(i); rd1_idx = 4'(15 - i); rd0_view = 3'd0; rd1_view = 3'd0;
            #1;
            chk("R12", rd0_data, model[i]);
            chk("R12", rd1_data, model[15 - i]);
        end

        finish_run();
    end
endmodule